// File: doc/BRIEF.md
# Shape Descriptor Cache with Instruction-Driven Update

This block stores tensor shape descriptors for an accelerator. Each descriptor holds three 16-bit dimension values. Descriptors are kept in two banks of 64 entries each. One bank holds feature-map shapes and the other holds weight shapes. Compute and copy instructions elsewhere in the chip refer to a descriptor only by a 6-bit pointer, and they read it back through one of the cache's read ports.

The block watches a stream of 64-bit instruction words, each qualified by a valid strobe. It acts only on the descriptor-write opcode. From that instruction it takes the bank code, the entry pointer and the three values, and it writes one entry. An instruction whose bank code names no existing bank writes nothing and raises a one-cycle error pulse. Each read port returns the descriptor at a given bank and pointer one clock after the request. If a read hits the entry being written in the same cycle, the port returns the new values. After reset, every entry reads as zero.

Top module: `shape_desc_cache`

## Requirements
- R1: While reset is asserted and after it is released, every entry of both banks reads as zero until it is written. Asserting reset again returns all entries to zero.
- R2: A valid instruction with opcode 0x3 in bits [63:60] and bank code 0 in bits [59:58] writes its descriptor into the feature-map bank.
- R3: The entry pointer is bits [57:52]. Value a is bits [51:36], value b is bits [35:20] and value c is bits [19:4]. The read descriptor is packed as {a, b, c}, with a in bits [47:32] and c in bits [15:0]. Bits [3:0] have no effect.
- R4: Bank code 1 writes the weight bank. An entry in one bank is independent of the entry with the same pointer in the other bank.
- R5: A valid descriptor-write instruction with bank code 2 or 3 changes no entry in either bank. It raises err_pulse for exactly one cycle, in the cycle after the instruction is accepted.
- R6: A valid instruction with any opcode other than 0x3 changes no entry and raises no error.
- R7: An instruction presented while instr_valid is low changes no entry and raises no error.
- R8: A read in the same cycle as a write to the same bank and pointer returns the newly written descriptor. A read of the other bank at the same pointer in that cycle returns that bank's stored descriptor.
- R9: The two read ports are independent. Each can read a different bank and pointer in the same cycle.
- R10: Read latency is one cycle. rd_desc reflects the bank and pointer presented before the most recent clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Qualifies instr for one cycle |
| instr | input | 64 | Instruction word |
| rd_bank | input | NRD x 1 | Bank select per read port (0 feature-map, 1 weight) |
| rd_ptr | input | NRD x 6 | Entry pointer per read port |
| rd_desc | output | NRD x 48 | Descriptor {a, b, c} per read port, one cycle after request |
| err_pulse | output | 1 | One-cycle pulse after a write with an invalid bank code |

## Verification
The bench builds the block with its defaults: two read ports and 64 entries per bank. This puts the highest pointer, 63, within reach, along with the top and bottom bits of every field. Two read ports make same-cycle bypass observable on one port while the other port reads the opposite bank at the same pointer. Bank code 3 is exercised separately from code 2 because its low bit would alias the weight bank if the range check were lost.

// File: rtl/shape_desc_pkg.sv
package shape_desc_pkg;
  // instruction format
  parameter int INSTR_W = 64;
  parameter int OPC_W   = 4;
  parameter int BANK_W  = 2;
  parameter int PTR_W   = 6;
  parameter int DIM_W   = 16;
  parameter int NBANK   = 2;
  parameter logic [OPC_W-1:0] OPC_DESC_WRITE = 4'h3;

  localparam int OPC_LSB  = INSTR_W - OPC_W;
  localparam int BANK_LSB = OPC_LSB - BANK_W;
  localparam int PTR_LSB  = BANK_LSB - PTR_W;
  localparam int DESC_W   = 3 * DIM_W;
  localparam int DESC_LSB = PTR_LSB - DESC_W;
  localparam int DEPTH    = 1 << PTR_W;
  localparam int BSEL_W   = (NBANK > 1) ? $clog2(NBANK) : 1;

  typedef struct packed {
    logic [DIM_W-1:0] a;
    logic [DIM_W-1:0] b;
    logic [DIM_W-1:0] c;
  } desc_t;
endpackage

// File: rtl/sdc_write_decode.sv
module sdc_write_decode
  import shape_desc_pkg::*;
(
  input  logic               instr_valid,
  input  logic [INSTR_W-1:0] instr,
  output logic [NBANK-1:0]   wr_en,
  output logic [PTR_W-1:0]   wr_ptr,
  output desc_t              wr_desc,
  output logic               bad_bank
);
  logic [OPC_W-1:0]  opc;
  logic [BANK_W-1:0] bank_code;
  logic              is_write;

  assign opc       = instr[OPC_LSB +: OPC_W];
  assign bank_code = instr[BANK_LSB +: BANK_W];
  assign wr_ptr    = instr[PTR_LSB +: PTR_W];
  assign wr_desc   = desc_t'(instr[DESC_LSB +: DESC_W]);
  assign is_write  = instr_valid && (opc == OPC_DESC_WRITE);
  assign bad_bank  = is_write && (int'(bank_code) >= NBANK);

  for (genvar g = 0; g < NBANK; g++) begin : g_sel
    assign wr_en[g] = is_write && (int'(bank_code) == g);
  end
endmodule

// File: rtl/sdc_bank.sv
module sdc_bank
  import shape_desc_pkg::*;
#(
  parameter int NRD = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [PTR_W-1:0]          wr_ptr,
  input  logic [DESC_W-1:0]         wr_data,
  input  logic [NRD-1:0][PTR_W-1:0] rd_ptr,
  output logic [NRD-1:0][DESC_W-1:0] rd_data
);
  logic [DESC_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  vld;

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  // per-entry written flags give an instant clear on reset
  always_ff @(posedge clk) begin
    if (rst)        vld <= '0;
    else if (wr_en) vld[wr_ptr] <= 1'b1;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    logic [DESC_W-1:0] q;
    logic [DESC_W-1:0] byp_q;
    logic              v_q;
    logic              hit_q;

    always_ff @(posedge clk) begin
      q     <= mem[rd_ptr[p]];
      byp_q <= wr_data;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        v_q   <= 1'b0;
        hit_q <= 1'b0;
      end else begin
        v_q   <= vld[rd_ptr[p]];
        hit_q <= wr_en && (wr_ptr == rd_ptr[p]);
      end
    end

    assign rd_data[p] = hit_q ? byp_q : (v_q ? q : '0);
  end
endmodule

// File: rtl/shape_desc_cache.sv
module shape_desc_cache
  import shape_desc_pkg::*;
#(
  parameter int NRD = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        instr_valid,
  input  logic [INSTR_W-1:0]          instr,
  input  logic [NRD-1:0][BSEL_W-1:0]  rd_bank,
  input  logic [NRD-1:0][PTR_W-1:0]   rd_ptr,
  output logic [NRD-1:0][DESC_W-1:0]  rd_desc,
  output logic                        err_pulse
);
  logic [NBANK-1:0] wr_en;
  logic [PTR_W-1:0] wr_ptr;
  desc_t            wr_desc;
  logic             bad_bank;

  sdc_write_decode i_dec (
    .instr_valid (instr_valid),
    .instr       (instr),
    .wr_en       (wr_en),
    .wr_ptr      (wr_ptr),
    .wr_desc     (wr_desc),
    .bad_bank    (bad_bank)
  );

  logic [NRD-1:0][DESC_W-1:0] bank_rd [NBANK];

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    sdc_bank #(.NRD(NRD)) i_bank (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en[g]),
      .wr_ptr  (wr_ptr),
      .wr_data (wr_desc),
      .rd_ptr  (rd_ptr),
      .rd_data (bank_rd[g])
    );
  end

  logic [NRD-1:0][BSEL_W-1:0] bank_q;

  always_ff @(posedge clk) begin
    if (rst) bank_q <= '0;
    else     bank_q <= rd_bank;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_port
    assign rd_desc[p] = bank_rd[bank_q[p]][p];
  end

  always_ff @(posedge clk) begin
    if (rst) err_pulse <= 1'b0;
    else     err_pulse <= bad_bank;
  end
endmodule

// File: rtl/sdc_checker.sv
module sdc_checker
  import shape_desc_pkg::*;
#(
  parameter int NRD = 2
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        instr_valid,
  input logic [INSTR_W-1:0]          instr,
  input logic [NRD-1:0][BSEL_W-1:0]  rd_bank,
  input logic [NRD-1:0][PTR_W-1:0]   rd_ptr,
  input logic [NRD-1:0][DESC_W-1:0]  rd_desc,
  input logic                        err_pulse
);
  logic is_wr;
  assign is_wr = instr_valid && (instr[OPC_LSB +: OPC_W] == OPC_DESC_WRITE);

  // R1: the cycle after reset, every port reads zero
  p_reset_zero_r1: assert property (@(posedge clk) $past(rst) |-> (rd_desc == '0));

  // R5: an error pulse has an accepted bad-bank write as its cause
  p_err_cause_r5: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> $past(is_wr && (int'(instr[BANK_LSB +: BANK_W]) >= NBANK)));

  // R6: other opcodes never raise the error
  p_no_err_other_r6: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && !is_wr) |=> !err_pulse);

  // R7: nothing valid, nothing flagged
  p_no_err_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !instr_valid |=> !err_pulse);

  // R8: same-cycle bypass on port 0
  p_bypass_r8: assert property (@(posedge clk) disable iff (rst)
    (is_wr && (int'(instr[BANK_LSB +: BANK_W]) == int'(rd_bank[0]))
       && (instr[PTR_LSB +: PTR_W] == rd_ptr[0]))
    |=> (rd_desc[0] == $past(instr[DESC_LSB +: DESC_W])));
endmodule

bind shape_desc_cache sdc_checker #(.NRD(NRD)) i_chk (
  .clk         (clk),
  .rst         (rst),
  .instr_valid (instr_valid),
  .instr       (instr),
  .rd_bank     (rd_bank),
  .rd_ptr      (rd_ptr),
  .rd_desc     (rd_desc),
  .err_pulse   (err_pulse)
);

// File: tb/test_shape_desc_cache.sv
module test_shape_desc_cache;
  localparam int CLK_PERIOD = 10;
  localparam int NRD = 2;

  logic              clk = 1'b0;
  logic              rst;
  logic              instr_valid;
  logic [63:0]       instr;
  logic [NRD-1:0][0:0]  rd_bank;
  logic [NRD-1:0][5:0]  rd_ptr;
  logic [NRD-1:0][47:0] rd_desc;
  logic              err_pulse;

  int total = 0;
  int bad   = 0;
  logic [47:0] model [2][64];
  logic        last_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  shape_desc_cache #(.NRD(NRD)) i_shape_desc_cache (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
    .rd_bank(rd_bank), .rd_ptr(rd_ptr), .rd_desc(rd_desc), .err_pulse(err_pulse)
  );

  function automatic logic [63:0] mk(input logic [3:0] op, input logic [1:0] bk,
      input logic [5:0] p, input logic [15:0] a, input logic [15:0] b,
      input logic [15:0] c, input logic [3:0] rsv);
    return {op, bk, p, a, b, c, rsv};
  endfunction

  task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, one posedge passes, back at negedge
  task automatic issue(input logic [63:0] w, input logic v);
    instr_valid = v;
    instr = w;
    @(negedge clk);
    instr_valid = 1'b0;
    instr = '0;
    last_err = err_pulse;
  endtask

  task automatic rd(input int p, input logic bk, input logic [5:0] ptr, output logic [47:0] d);
    rd_bank[p] = bk;
    rd_ptr[p] = ptr;
    @(negedge clk);
    d = rd_desc[p];
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < 64; i++) model[b][i] = '0;
  endtask

  task automatic t_reset(input string tag);
    logic [47:0] d;
    rd(0, 1'b0, 6'd0, d);  check(tag, d, 48'h0);
    rd(0, 1'b1, 6'd63, d); check(tag, d, 48'h0);
    rd(1, 1'b0, 6'd63, d); check(tag, d, 48'h0);
    rd(1, 1'b1, 6'd9, d);  check(tag, d, 48'h0);
  endtask

  task automatic t_basic();
    logic [47:0] d;
    issue(mk(4'h3, 2'd0, 6'h12, 16'h8001, 16'h4002, 16'hC003, 4'hF), 1'b1);
    model[0][6'h12] = {16'h8001, 16'h4002, 16'hC003};
    check("R2 err", {47'd0, last_err}, 48'h0);
    rd(0, 1'b0, 6'h12, d); check("R2/R3", d, model[0][6'h12]);
    issue(mk(4'h3, 2'd0, 6'd63, 16'hFFFF, 16'h0000, 16'h0001, 4'h5), 1'b1);
    model[0][63] = {16'hFFFF, 16'h0000, 16'h0001};
    rd(0, 1'b0, 6'd63, d); check("R3 ptr63", d, model[0][63]);
    rd(0, 1'b0, 6'd62, d); check("R3 neighbour", d, 48'h0);
  endtask

  task automatic t_banks();
    logic [47:0] d;
    issue(mk(4'h3, 2'd1, 6'h12, 16'h1111, 16'h2222, 16'h3333, 4'h0), 1'b1);
    model[1][6'h12] = {16'h1111, 16'h2222, 16'h3333};
    issue(mk(4'h3, 2'd1, 6'd9, 16'hAAAA, 16'hBBBB, 16'hCCCC, 4'h0), 1'b1);
    model[1][9] = {16'hAAAA, 16'hBBBB, 16'hCCCC};
    rd(1, 1'b1, 6'h12, d); check("R4 weight", d, model[1][6'h12]);
    rd(1, 1'b0, 6'h12, d); check("R4 fmap", d, model[0][6'h12]);
  endtask

  task automatic t_bad_bank();
    logic [47:0] d;
    issue(mk(4'h3, 2'd2, 6'h12, 16'hDEAD, 16'hBEEF, 16'h0BAD, 4'h0), 1'b1);
    check("R5 err code2", {47'd0, last_err}, 48'h1);
    @(negedge clk);
    check("R5 err one cycle", {47'd0, err_pulse}, 48'h0);
    issue(mk(4'h3, 2'd3, 6'h12, 16'h5A5A, 16'hA5A5, 16'h7777, 4'h0), 1'b1);
    check("R5 err code3", {47'd0, last_err}, 48'h1);
    rd(0, 1'b0, 6'h12, d); check("R5 fmap kept", d, model[0][6'h12]);
    rd(0, 1'b1, 6'h12, d); check("R5 weight kept", d, model[1][6'h12]);
  endtask

  task automatic t_other_op();
    logic [47:0] d;
    issue(mk(4'h2, 2'd0, 6'h12, 16'h1234, 16'h5678, 16'h9ABC, 4'h0), 1'b1);
    check("R6 no err", {47'd0, last_err}, 48'h0);
    issue(mk(4'hB, 2'd1, 6'h12, 16'h1234, 16'h5678, 16'h9ABC, 4'h0), 1'b1);
    issue(mk(4'h7, 2'd2, 6'h12, 16'h1234, 16'h5678, 16'h9ABC, 4'h0), 1'b1);
    check("R6 no err bad bank", {47'd0, last_err}, 48'h0);
    rd(0, 1'b0, 6'h12, d); check("R6 fmap", d, model[0][6'h12]);
    rd(0, 1'b1, 6'h12, d); check("R6 weight", d, model[1][6'h12]);
  endtask

  task automatic t_valid_low();
    logic [47:0] d;
    issue(mk(4'h3, 2'd0, 6'h12, 16'h0F0F, 16'hF0F0, 16'h00FF, 4'h0), 1'b0);
    issue(mk(4'h3, 2'd2, 6'h12, 16'h0F0F, 16'hF0F0, 16'h00FF, 4'h0), 1'b0);
    check("R7 no err", {47'd0, last_err}, 48'h0);
    rd(0, 1'b0, 6'h12, d); check("R7 unchanged", d, model[0][6'h12]);
  endtask

  task automatic t_bypass();
    rd_bank[0] = 1'b0; rd_ptr[0] = 6'd9;
    rd_bank[1] = 1'b1; rd_ptr[1] = 6'd9;
    issue(mk(4'h3, 2'd0, 6'd9, 16'h0102, 16'h0304, 16'h0506, 4'h0), 1'b1);
    model[0][9] = {16'h0102, 16'h0304, 16'h0506};
    check("R8 bypass", rd_desc[0], model[0][9]);
    check("R8 other bank", rd_desc[1], model[1][9]);
  endtask

  task automatic t_dual_latency();
    rd_bank[0] = 1'b1; rd_ptr[0] = 6'h12;
    rd_bank[1] = 1'b0; rd_ptr[1] = 6'd63;
    @(negedge clk);
    check("R9 port0", rd_desc[0], model[1][6'h12]);
    check("R9 port1", rd_desc[1], model[0][63]);
    rd_ptr[0] = 6'd9;
    #1;
    check("R10 holds old", rd_desc[0], model[1][6'h12]);
    @(negedge clk);
    check("R10 new", rd_desc[0], model[1][9]);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    instr_valid = 1'b0;
    instr = '0;
    rd_bank = '0;
    rd_ptr = '0;
    last_err = 1'b0;
    @(negedge clk);
    do_reset();
    t_reset("R1 after reset");
    t_basic();
    t_banks();
    t_bad_bank();
    t_other_op();
    t_valid_low();
    t_bypass();
    t_dual_latency();
    do_reset();
    t_reset("R1 reset again");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule